// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero-Bit Insertion

This block turns a frame, handed over one byte at a time on a valid/ready port with an end-of-frame marker, into a serial HDLC bit stream. It sends an opening flag, then the payload bits, each byte least significant bit first, then a 16-bit frame check sequence, then closing flags. Inside the payload and the check sequence, a zero is inserted after every run of five ones so that the flag pattern cannot appear in the data.

The check sequence is computed bit by bit while the payload leaves the block. It is inverted at the end and sent low byte first through the same zero-insertion path. Output bits appear on `bit_out`, qualified by `bit_en`, at most one per clock. When the upstream source has no byte ready in the middle of a frame, the strobe simply stays low until a byte arrives. Channel access, key-up timing and modulation sit outside this block, and frame length is checked upstream.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, and between frames, `bit_en` stays low and `in_ready` stays low while `in_valid` is low. A frame starts only when `in_valid` is seen high in the idle state, and the idle cycle itself emits no bit.
- R2: The first 8 strobed bits of a frame are the flag 0x7E sent least significant bit first (0,1,1,1,1,1,1,0), with no zero insertion.
- R3: Each payload byte is sent least significant bit first. The first bit of an accepted byte appears on `bit_out`, with `bit_en` high, in the cycle after the handshake.
- R4: In the payload and the check sequence, a 0 is inserted after five consecutive 1 bits, and the run count restarts from zero after the inserted bit. For example, 0xFF bytes yield 11111 0 11111 0 and so on.
- R5: `in_ready` is low in every cycle in which an inserted zero is output, and no payload byte or bit is lost or duplicated, even when all bytes are 0xFF and are always valid.
- R6: After the last payload bit, the 16-bit check sequence follows: reflected CRC-CCITT (polynomial 0x8408, preset 0xFFFF) over the payload, inverted, low byte first, each byte least significant bit first, with zero insertion.
- R7: The frame ends with two flags of 0x7E (16 bits) with no zero insertion. After that, the block returns to idle and emits nothing more.
- R8: If no byte is offered in the middle of a frame, the block waits with `in_ready` high and `bit_en` low, and it resumes the frame when the next byte is accepted.
- R9: A synchronous reset in the middle of a frame stops the output in the next cycle, returns the block to idle with `in_ready` low, and a following frame is sent correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A payload byte is offered |
| in_data | input | DATA_W | Payload byte |
| in_last | input | 1 | The offered byte is the last of the frame |
| in_ready | output | 1 | The framer takes the offered byte in this cycle |
| bit_out | output | 1 | Serial line bit |
| bit_en | output | 1 | `bit_out` carries a line bit in this cycle |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 0x7E flag, two closing flags, a run limit of five, and the 0x8408/0xFFFF check sequence. With these values, a known 9-byte ASCII frame, all-ones payloads and a payload equal to the flag are all in reach. Runs of ones then cross byte boundaries, cross the boundary from payload into check sequence, and fall on the final bit of a byte, where an inserted zero must hold off the next handshake. Mid-frame underrun, reset in the middle of a frame and back-to-back frames are also exercised.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE
  } tx_state_e;

  // one reflected CRC step for a single line bit
  function automatic logic [15:0] crc_bit_step(input logic [15:0] c,
                                               input logic        b,
                                               input logic [15:0] poly);
    logic fb;
    fb = c[0] ^ b;
    crc_bit_step = (c >> 1) ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen #(
  parameter int            FCS_W = 16,
  parameter logic [15:0]   POLY  = 16'h8408,
  parameter logic [15:0]   INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [FCS_W-1:0] crc_upd_o
);
  import hdlc_tx_pkg::*;

  logic [FCS_W-1:0] crc_q;

  always_comb begin
    crc_upd_o = crc_bit_step(crc_q, bit_i, POLY);
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      crc_q <= INIT;
    end else if (step_i) begin
      crc_q <= crc_upd_o;
    end
  end

endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  input  logic ins_i,
  output logic due_o,
  output logic due_next_o
);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (clr_i || ins_i) begin
      run_d = '0;
    end else if (step_i) begin
      run_d = bit_i ? run_q + RUN_W'(1) : '0;
    end
    due_o      = (run_q == RUN_W'(RUN_MAX));
    due_next_o = (run_d == RUN_W'(RUN_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq #(
  parameter int               DATA_W  = 8,
  parameter int               FLAG_W  = 8,
  parameter logic [FLAG_W-1:0] FLAG   = 8'h7E,
  parameter int               N_CLOSE = 2,
  parameter int               FCS_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              bit_out,
  output logic              bit_en,
  input  logic [FCS_W-1:0]  crc_upd,
  input  logic              stuff_due,
  input  logic              stuff_due_next,
  output logic              crc_init,
  output logic              crc_step,
  output logic              line_bit,
  output logic              run_clr,
  output logic              run_step,
  output logic              stuff_ins,
  output logic              byte_take,
  output logic              frame_start,
  output logic              frame_end
);
  import hdlc_tx_pkg::*;

  localparam int CLOSE_W = FLAG_W * N_CLOSE;
  localparam int SH_A    = (FCS_W > CLOSE_W) ? FCS_W : CLOSE_W;
  localparam int SH_W    = (SH_A > DATA_W) ? SH_A : DATA_W;
  localparam int CNT_W   = $clog2(SH_W + 1);

  tx_state_e        state_q, state_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, last_d;
  logic             emit;
  logic             bit_q, en_q;
  logic [CLOSE_W-1:0] close_pat;
  logic [FCS_W-1:0]   fcs_val;

  for (genvar g = 0; g < N_CLOSE; g++) begin : g_close
    assign close_pat[g*FLAG_W +: FLAG_W] = FLAG;
  end

  assign fcs_val = ~crc_upd;

  always_comb begin
    state_d     = state_q;
    sh_d        = sh_q;
    cnt_d       = cnt_q;
    last_d      = last_q;
    emit        = 1'b0;
    line_bit    = 1'b0;
    crc_init    = 1'b0;
    crc_step    = 1'b0;
    run_clr     = 1'b0;
    run_step    = 1'b0;
    stuff_ins   = 1'b0;
    in_ready    = 1'b0;
    byte_take   = 1'b0;
    frame_start = 1'b0;
    frame_end   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d     = ST_OPEN;
          sh_d        = SH_W'(FLAG);
          cnt_d       = CNT_W'(FLAG_W);
          frame_start = 1'b1;
          crc_init    = 1'b1;
          run_clr     = 1'b1;
        end
      end
      ST_OPEN: begin
        emit     = 1'b1;
        line_bit = sh_q[0];
        sh_d     = sh_q >> 1;
        cnt_d    = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          state_d = ST_DATA;
          last_d  = 1'b0;
        end
      end
      ST_DATA, ST_FCS: begin
        if (stuff_due) begin
          emit      = 1'b1;
          line_bit  = 1'b0;
          stuff_ins = 1'b1;
          if (state_q == ST_FCS && cnt_q == '0) begin
            state_d = ST_CLOSE;
            sh_d    = SH_W'(close_pat);
            cnt_d   = CNT_W'(CLOSE_W);
          end
        end else if (cnt_q != '0) begin
          emit     = 1'b1;
          line_bit = sh_q[0];
          sh_d     = sh_q >> 1;
          cnt_d    = cnt_q - CNT_W'(1);
          run_step = 1'b1;
          crc_step = (state_q == ST_DATA);
          if (cnt_q == CNT_W'(1)) begin
            if (state_q == ST_DATA && last_q) begin
              state_d = ST_FCS;
              sh_d    = SH_W'(fcs_val);
              cnt_d   = CNT_W'(FCS_W);
            end else if (state_q == ST_FCS && !stuff_due_next) begin
              state_d = ST_CLOSE;
              sh_d    = SH_W'(close_pat);
              cnt_d   = CNT_W'(CLOSE_W);
            end
          end
        end else if (state_q == ST_DATA) begin
          in_ready = 1'b1;
          if (in_valid) begin
            byte_take = 1'b1;
            emit      = 1'b1;
            line_bit  = in_data[0];
            sh_d      = SH_W'(in_data >> 1);
            cnt_d     = CNT_W'(DATA_W - 1);
            last_d    = in_last;
            run_step  = 1'b1;
            crc_step  = 1'b1;
          end
        end
      end
      ST_CLOSE: begin
        emit     = 1'b1;
        line_bit = sh_q[0];
        sh_d     = sh_q >> 1;
        cnt_d    = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          state_d   = ST_IDLE;
          frame_end = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      bit_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      bit_q   <= emit & line_bit;
      en_q    <= emit;
    end
  end

  assign bit_out = bit_q;
  assign bit_en  = en_q;

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int                DATA_W  = 8,
  parameter int                FLAG_W  = 8,
  parameter logic [FLAG_W-1:0] FLAG    = 8'h7E,
  parameter int                N_CLOSE = 2,
  parameter int                RUN_MAX = 5,
  parameter int                FCS_W   = 16,
  parameter logic [15:0]       POLY    = 16'h8408,
  parameter logic [15:0]       INIT    = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              bit_out,
  output logic              bit_en
);

  logic [FCS_W-1:0] w_crc_upd;
  logic w_crc_init, w_crc_step, w_line_bit;
  logic w_run_clr, w_run_step, w_stuff_ins;
  logic w_stuff_due, w_stuff_due_next;
  logic w_byte_take, w_frame_start, w_frame_end;

  hdlc_tx_seq #(
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W),
    .FLAG   (FLAG),
    .N_CLOSE(N_CLOSE),
    .FCS_W  (FCS_W)
  ) i_seq (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_last       (in_last),
    .in_ready      (in_ready),
    .bit_out       (bit_out),
    .bit_en        (bit_en),
    .crc_upd       (w_crc_upd),
    .stuff_due     (w_stuff_due),
    .stuff_due_next(w_stuff_due_next),
    .crc_init      (w_crc_init),
    .crc_step      (w_crc_step),
    .line_bit      (w_line_bit),
    .run_clr       (w_run_clr),
    .run_step      (w_run_step),
    .stuff_ins     (w_stuff_ins),
    .byte_take     (w_byte_take),
    .frame_start   (w_frame_start),
    .frame_end     (w_frame_end)
  );

  hdlc_fcs_gen #(
    .FCS_W(FCS_W),
    .POLY (POLY),
    .INIT (INIT)
  ) i_fcs (
    .clk      (clk),
    .rst      (rst),
    .init_i   (w_crc_init),
    .step_i   (w_crc_step),
    .bit_i    (w_line_bit),
    .crc_upd_o(w_crc_upd)
  );

  hdlc_zero_ins #(
    .RUN_MAX(RUN_MAX)
  ) i_zins (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (w_run_clr),
    .step_i    (w_run_step),
    .bit_i     (w_line_bit),
    .ins_i     (w_stuff_ins),
    .due_o     (w_stuff_due),
    .due_next_o(w_stuff_due_next)
  );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              bit_out,
  input logic              bit_en,
  input logic              stuff_ins,
  input logic              byte_take,
  input logic              frame_start,
  input logic              frame_end
);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bit_en && !in_ready));

  // R1
  idle_cycle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !bit_en);

  // R2
  open_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> ##1 (bit_en && !bit_out));

  // R3
  take_lsb_first_chk: assert property (@(posedge clk) disable iff (rst)
    byte_take |=> (bit_en && (bit_out == $past(in_data[0]))));

  // R4
  stuffed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stuff_ins |=> (bit_en && !bit_out));

  // R5
  no_ready_in_stuff_chk: assert property (@(posedge clk) disable iff (rst)
    stuff_ins |-> !in_ready);

  // R7
  close_last_bit_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (bit_en && !bit_out));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .bit_out    (bit_out),
  .bit_en     (bit_en),
  .stuff_ins  (w_stuff_ins),
  .byte_take  (w_byte_take),
  .frame_start(w_frame_start),
  .frame_end  (w_frame_end)
);

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready, bit_out, bit_en;

  int total = 0;
  int bad = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [7:0] frm[$];

  always #(CLK_P/2) clk = ~clk;

  hdlc_tx_framer i_hdlc_tx_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .bit_out(bit_out), .bit_en(bit_en)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // byte-wise reflected CRC-CCITT, written independently of the bit loop
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c[7:0] ^ b;
    x = x ^ (x << 4);
    return (c >> 8) ^ {x, 8'h00} ^ {5'b0, x, 3'b0} ^ {12'b0, x[7:4]};
  endfunction

  task automatic expect_frame(input string dtag);
    int ones;
    logic [15:0] c;
    logic [15:0] f;
    for (int i = 0; i < 8; i++) begin exp_q.push_back(1'(8'h7E >> i)); tag_q.push_back("R2"); end
    ones = 0;
    c = 16'hFFFF;
    foreach (frm[k]) begin
      c = crc_byte(c, frm[k]);
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back(frm[k][i]); tag_q.push_back(dtag);
        ones = frm[k][i] ? ones + 1 : 0;
        if (ones == 5) begin exp_q.push_back(1'b0); tag_q.push_back("R4"); ones = 0; end
      end
    end
    f = ~c;
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back(f[i]); tag_q.push_back("R6");
      ones = f[i] ? ones + 1 : 0;
      if (ones == 5) begin exp_q.push_back(1'b0); tag_q.push_back("R4"); ones = 0; end
    end
    for (int i = 0; i < 16; i++) begin exp_q.push_back(1'(8'h7E >> (i % 8))); tag_q.push_back("R7"); end
  endtask

  // called just after a falling edge
  task automatic put(input logic [7:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain_and_idle(input string tag);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, "R7", {tag, " all bits sent"}, exp_q.size(), 0);
    repeat (6) @(negedge clk);
    check(bit_en == 1'b0, "R1", {tag, " idle bit_en"}, bit_en, 0);
    check(in_ready == 1'b0, "R1", {tag, " idle in_ready"}, in_ready, 0);
  endtask

  task automatic send_frame(input string dtag, input int gap, input string name);
    expect_frame(dtag);
    foreach (frm[k]) begin
      put(frm[k], k == frm.size() - 1);
      if (gap > 0 && k == 1) begin
        repeat (gap) @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R8", {name, " waiting ready"}, in_ready, 1);
        check(bit_en == 1'b0, "R8", {name, " no filler bits"}, bit_en, 0);
        @(negedge clk);
      end
    end
    drain_and_idle(name);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && bit_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected bit", bit_out, 0);
      end else begin
        bit    b;
        string t;
        b = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bit_out == b, t, "line bit", bit_out, b);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(bit_en == 1'b0, "R1", "reset bit_en", bit_en, 0);
    check(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);

    frm = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_frame("R3", 0, "ascii");
    frm = {8'h01, 8'h80, 8'h55};
    send_frame("R3", 0, "short");
    frm = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    send_frame("R5", 0, "ones");
    frm = {8'h7E};
    send_frame("R4", 0, "flagbyte");
    frm = {8'hF8, 8'h1F, 8'hFC, 8'h3F, 8'hE0};
    send_frame("R8", 20, "gap");

    // back-to-back frames without a wait in between
    frm = {8'hAA, 8'h0F};
    expect_frame("R3");
    foreach (frm[k]) put(frm[k], k == frm.size() - 1);
    frm = {8'hF0, 8'h3E};
    expect_frame("R3");
    foreach (frm[k]) put(frm[k], k == frm.size() - 1);
    drain_and_idle("b2b");

    // reset in the middle of a frame
    frm = {8'hA5, 8'h3C, 8'h0F, 8'hF0};
    expect_frame("R9");
    put(frm[0], 1'b0);
    put(frm[1], 1'b0);
    repeat (3) @(negedge clk);
    #2;
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    repeat (2) @(negedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    check(bit_en == 1'b0, "R9", "after reset bit_en", bit_en, 0);
    check(in_ready == 1'b0, "R9", "after reset in_ready", in_ready, 0);
    frm = {8'h12, 8'hFE, 8'h7F};
    send_frame("R9", 0, "post-reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule